// File: doc/BRIEF.md
# Page Write Collector and Commit Sequencer

This block sits between a serial-bus slave front end and a nonvolatile memory array. It gathers the data bytes of one write transaction into a page-sized staging buffer and keeps a pointer inside that page. When the transaction closes, it runs a self-timed write cycle. During that cycle it offers every received byte to the array, one offset per clock. A protection unit may veto individual bytes.

The front end marks a transaction start together with the 12-bit target address. It then presents each received byte with a one-cycle strobe and marks the end of the transaction. Only the low five address bits move as bytes arrive. Surplus bytes therefore wrap and replace earlier ones in the same page, and the array sees nothing until the transaction ends. The write cycle lasts a parameterised number of clocks. Throughout it the block reports busy and disregards all front-end strobes.

Top module: `page_write_seq`

## Requirements
- R1: After reset, busy_o and mem_we_o are low.
- R2: A start latches the page tag (address bits 11..5) and the in-page offset (bits 4..0). Each accepted byte is stored at the current offset, and then only the offset advances by one, modulo 32. The tag never changes during a transaction.
- R3: If more than 32 bytes arrive before the stop, the offset wraps from 31 to 0. A later byte at an offset replaces the earlier one, and only the last value at each offset is committed.
- R4: No write strobe occurs outside a write cycle. busy_o rises on the clock edge that samples an accepted stop and not before.
- R5: busy_o stays high for exactly WRITE_CYCLES clocks (at least 32). While busy_o is high, start_i, byte_valid_i and stop_i have no effect.
- R6: In write-cycle clock k (k = 0..31), mem_addr_o = {tag, k} and mem_data_o is the byte buffered at offset k. mem_we_o pulses only for offsets that received a byte since the last start. Clocks 32 and later of the write cycle carry no strobe.
- R7: A stop with no byte received since the start does not begin a write cycle. Bytes and stops outside a transaction (no start since the last stop) are ignored.
- R8: mem_we_o requires permit_i to be high in the same clock. permit_i is evaluated combinationally for the address on mem_addr_o, and a refused byte is skipped.
- R9: A byte strobe in the same clock as the stop is stored and committed. It alone is enough to start the write cycle.
- R10: A start discards the previous valid mask. A byte strobe in the same clock as a start is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Transaction start strobe |
| start_addr_i | input | ADDR_W | Target address, sampled with start_i |
| byte_valid_i | input | 1 | Data byte strobe |
| byte_i | input | 8 | Data byte |
| stop_i | input | 1 | Transaction end strobe |
| permit_i | input | 1 | Write permission for the address on mem_addr_o |
| busy_o | output | 1 | Write cycle in progress |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_data_o | output | 8 | Array write data |

## Verification
Two functions can meet in one clock: storing a byte and ending the transaction. A final byte strobe raised together with the stop must still be buffered and counted as received. This holds even when it is the only byte, so an otherwise empty transaction becomes a real write cycle. The bench provokes this directly and in random transactions. It judges the result from the strobes that appear during the following write cycle, compared against a bench model of the page. It likewise collides a start with a byte and expects that byte to vanish.

// File: rtl/pws_pkg.sv
package pws_pkg;
  localparam int unsigned DATA_W = 8;
  typedef logic [DATA_W-1:0] byte_t;
endpackage

// File: rtl/pws_page_buf.sv
module pws_page_buf import pws_pkg::*; #(
  parameter int unsigned PAGE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [PAGE_W-1:0] wr_idx_i,
  input  byte_t             wr_data_i,
  input  logic [PAGE_W-1:0] rd_idx_i,
  output byte_t             rd_data_o,
  output logic              rd_valid_o,
  output logic              any_o
);
  localparam int unsigned PAGE_BYTES = 1 << PAGE_W;

  byte_t                 data_w [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld_w;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    byte_t d_q;
    logic  v_q;
    logic  hit;
    assign hit = wr_i && (wr_idx_i == PAGE_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        d_q <= '0;
        v_q <= 1'b0;
      end else if (hit) begin
        d_q <= wr_data_i;
        v_q <= 1'b1;
      end else if (clr_i) begin
        v_q <= 1'b0;
      end
    end
    assign data_w[g] = d_q;
    assign vld_w[g]  = v_q;
  end

  assign rd_data_o  = data_w[rd_idx_i];
  assign rd_valid_o = vld_w[rd_idx_i];
  assign any_o      = |vld_w;
endmodule

// File: rtl/pws_timer.sv
module pws_timer #(
  parameter int unsigned PAGE_W       = 5,
  parameter int unsigned WRITE_CYCLES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  output logic              busy_o,
  output logic              scan_o,
  output logic [PAGE_W-1:0] idx_o
);
  localparam int unsigned PAGE_BYTES = 1 << PAGE_W;
  localparam int unsigned TOTAL = (WRITE_CYCLES > PAGE_BYTES) ? WRITE_CYCLES : PAGE_BYTES;
  localparam int unsigned CNT_W = $clog2(TOTAL + 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last;

  assign last = (cnt_q == CNT_W'(TOTAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (go_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end else if (last) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign scan_o = busy_q && (cnt_q < CNT_W'(PAGE_BYTES));
  assign idx_o  = cnt_q[PAGE_W-1:0];
endmodule

// File: rtl/page_write_seq.sv
module page_write_seq import pws_pkg::*; #(
  parameter int unsigned ADDR_W       = 12,
  parameter int unsigned PAGE_W       = 5,
  parameter int unsigned WRITE_CYCLES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  input  logic              stop_i,
  input  logic              permit_i,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_data_o
);
  localparam int unsigned TAG_W = ADDR_W - PAGE_W;

  logic              active_q;
  logic [TAG_W-1:0]  tag_q;
  logic [PAGE_W-1:0] ptr_q;
  logic              busy, scan, slot_vld, any_vld;
  logic [PAGE_W-1:0] scan_idx;
  byte_t             slot_data;
  logic              take_start, take_byte, take_stop, go;

  // start wins over a byte or stop in the same clock
  assign take_start = start_i && !busy;
  assign take_byte  = byte_valid_i && active_q && !busy && !start_i;
  assign take_stop  = stop_i && active_q && !busy && !start_i;
  assign go         = take_stop && (any_vld || take_byte);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      tag_q    <= '0;
      ptr_q    <= '0;
    end else begin
      if (take_start) begin
        active_q <= 1'b1;
        tag_q    <= start_addr_i[ADDR_W-1:PAGE_W];
        ptr_q    <= start_addr_i[PAGE_W-1:0];
      end else begin
        if (take_byte) ptr_q <= ptr_q + 1'b1;
        if (take_stop) active_q <= 1'b0;
      end
    end
  end

  pws_page_buf #(.PAGE_W(PAGE_W)) i_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (take_start),
    .wr_i       (take_byte),
    .wr_idx_i   (ptr_q),
    .wr_data_i  (byte_i),
    .rd_idx_i   (scan_idx),
    .rd_data_o  (slot_data),
    .rd_valid_o (slot_vld),
    .any_o      (any_vld)
  );

  pws_timer #(.PAGE_W(PAGE_W), .WRITE_CYCLES(WRITE_CYCLES)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (go),
    .busy_o (busy),
    .scan_o (scan),
    .idx_o  (scan_idx)
  );

  assign busy_o     = busy;
  assign mem_addr_o = {tag_q, scan_idx};
  assign mem_data_o = slot_data;
  assign mem_we_o   = scan && slot_vld && permit_i;
endmodule

// File: rtl/pws_checker.sv
module pws_checker #(
  parameter int unsigned ADDR_W       = 12,
  parameter int unsigned PAGE_W       = 5,
  parameter int unsigned WRITE_CYCLES = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stop_i,
  input logic              permit_i,
  input logic              busy_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o
);
  localparam int unsigned PAGE_BYTES = 1 << PAGE_W;
  localparam int unsigned TOTAL = (WRITE_CYCLES > PAGE_BYTES) ? WRITE_CYCLES : PAGE_BYTES;
  localparam int unsigned CNT_W = $clog2(TOTAL + 1);

  logic [CNT_W-1:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else         run_q <= busy_o ? run_q + 1'b1 : '0;
  end

  a_r4_no_strobe_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_we_o);
  a_r4_busy_after_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(stop_i));
  a_r8_strobe_permitted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> permit_i);
  a_r2_tag_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(mem_addr_o[ADDR_W-1:PAGE_W]));
  a_r6_scan_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && run_q < CNT_W'(PAGE_BYTES)) |-> (mem_addr_o[PAGE_W-1:0] == run_q[PAGE_W-1:0]));
  a_r6_quiet_tail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && run_q >= CNT_W'(PAGE_BYTES)) |-> !mem_we_o);
  a_r5_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (run_q < CNT_W'(TOTAL)));
  a_r5_full_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> ($past(run_q) == CNT_W'(TOTAL - 1)));
endmodule

bind page_write_seq pws_checker #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WRITE_CYCLES(WRITE_CYCLES)
) i_pws_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .stop_i     (stop_i),
  .permit_i   (permit_i),
  .busy_o     (busy_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o)
);

// File: tb/test_page_write_seq.sv
module test_page_write_seq;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int PAGE_W = 5;
  localparam int PAGE = 32;
  localparam int WCYC = 40;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] saddr = '0;
  logic              bv = 1'b0;
  logic [7:0]        bd = '0;
  logic              stop = 1'b0;
  logic              permit;
  logic              busy, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0]        mem_data;
  logic              deny_en = 1'b0;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic       got_we  [PAGE];
  logic [7:0] got_dat [PAGE];
  logic       exp_we  [PAGE];
  logic [7:0] exp_dat [PAGE];
  logic [6:0] exp_tag;
  int         bcnt;
  int         addr_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic allowed(input logic [ADDR_W-1:0] a, input logic den);
    return !den || (a[1:0] != 2'b11);
  endfunction

  assign permit = allowed(mem_addr, deny_en);

  page_write_seq #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WRITE_CYCLES(WCYC)) i_page_write_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_addr_i(saddr),
    .byte_valid_i(bv), .byte_i(bd), .stop_i(stop), .permit_i(permit),
    .busy_o(busy), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_data_o(mem_data)
  );

  always @(negedge clk) begin
    if (rst_n && busy) begin
      if (mem_we) begin
        got_we[mem_addr[4:0]]  = 1'b1;
        got_dat[mem_addr[4:0]] = mem_data;
        if (mem_addr[11:5] != exp_tag || mem_addr[4:0] != bcnt[4:0] || bcnt >= PAGE)
          addr_err++;
      end
      bcnt++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_stop_probe(input string req);
    @(negedge clk) stop = 1'b1;
    @(negedge clk) stop = 1'b0;
    check(busy == 1'b0, req, busy, 0);
    repeat (2) @(negedge clk);
    check(busy == 1'b0, req, busy, 0);
  endtask

  // one write transaction against the bench model
  task automatic run_txn(input logic [ADDR_W-1:0] sa, input int n, input bit den,
                         input bit stop_last, input bit junk_start, input bit noise);
    logic [4:0] ptr;
    int guard;
    for (int i = 0; i < PAGE; i++) begin
      got_we[i] = 1'b0; exp_we[i] = 1'b0; got_dat[i] = '0; exp_dat[i] = '0;
    end
    bcnt = 0; addr_err = 0;
    exp_tag = sa[11:5];
    ptr = sa[4:0];
    deny_en = den;
    @(negedge clk);
    start = 1'b1; saddr = sa;
    if (junk_start) begin bv = 1'b1; bd = 8'($urandom); end  // R10 dropped byte
    @(negedge clk);
    start = 1'b0; bv = 1'b0; saddr = 12'($urandom);
    for (int i = 0; i < n; i++) begin
      int gap = $urandom_range(0, 2);
      repeat (gap) @(negedge clk);
      bv = 1'b1; bd = 8'($urandom);
      exp_we[ptr] = 1'b1; exp_dat[ptr] = bd;
      ptr = ptr + 5'd1;
      if (i == n - 1 && stop_last) stop = 1'b1;  // R9 byte with stop
      @(negedge clk);
      bv = 1'b0; stop = 1'b0;
      if (!(i == n - 1 && stop_last)) check(busy == 1'b0, "R4 early busy", busy, 0);
    end
    if (!(n > 0 && stop_last)) begin
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
    end
    if (n == 0) begin
      check(busy == 1'b0, "R7 empty stop", busy, 0);
      repeat (3) @(negedge clk);
      check(busy == 1'b0, "R7 empty stop later", busy, 0);
      return;
    end
    check(busy == 1'b1, "R4 busy after stop", busy, 1);
    guard = 0;
    while (busy && guard < 1000) begin
      if (noise) begin
        start = 1'($urandom); saddr = 12'($urandom);
        bv = 1'($urandom); bd = 8'($urandom); stop = 1'($urandom);
      end
      @(negedge clk);
      guard++;
    end
    start = 1'b0; bv = 1'b0; stop = 1'b0;
    check(bcnt == WCYC, "R5 busy length", bcnt, WCYC);
    check(addr_err == 0, "R6 scan address", addr_err, 0);
    for (int i = 0; i < PAGE; i++) begin
      logic e;
      e = exp_we[i] && allowed({exp_tag, 5'(i)}, den);
      check(got_we[i] == e, den ? "R8 permit gating" : "R6 strobe mask", got_we[i], e);
      if (e) check(got_dat[i] == exp_dat[i], "R3 R2 data", got_dat[i], exp_dat[i]);
    end
    if (noise) idle_stop_probe("R5 inputs ignored while busy");
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && mem_we == 1'b0, "R1 reset", {busy, mem_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && mem_we == 1'b0, "R1 after release", {busy, mem_we}, 0);

    run_txn(12'h0A3, 4, 0, 0, 0, 0);   // R2
    run_txn(12'h7DE, 40, 0, 0, 0, 0);  // R3 wrap from offset 30
    run_txn(12'h345, 0, 0, 0, 0, 0);   // R7 empty
    run_txn(12'h100, 1, 0, 1, 0, 0);   // R9 single byte with stop
    run_txn(12'h2E0, 3, 0, 1, 0, 0);   // R9
    run_txn(12'h400, 0, 0, 0, 1, 0);   // R10 junk only
    run_txn(12'h401, 3, 0, 0, 1, 0);   // R10 junk then data
    run_txn(12'hFE0, 32, 1, 0, 0, 0);  // R8
    run_txn(12'h555, 6, 0, 0, 0, 1);   // R5 noise during busy

    // R7 bytes and stop outside a transaction
    repeat (3) begin
      @(negedge clk) bv = 1'b1; bd = 8'hA5;
      @(negedge clk) bv = 1'b0;
    end
    idle_stop_probe("R7 stray stop");

    for (int t = 0; t < 14; t++) begin
      run_txn(12'($urandom), $urandom_range(0, 44), 1'($urandom), 1'($urandom),
              1'($urandom), 1'($urandom));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule